// File: doc/BRIEF.md
# USB Host Enumeration Sequencer

This block walks a freshly attached USB device through the host-side bring-up: it notices the attach, waits for the first bus reset to finish, starts a descriptor read, waits for a second bus reset, and then declares the port ready for traffic. It does not move any data itself. It watches the host controller's interrupt flag byte whenever the active-low interrupt line is asserted. It writes every flag it serviced back to the controller as an acknowledge. It raises one-cycle requests to set or clear the start-of-frame keep-alive mode bit, and a one-cycle pulse that starts the descriptor fetch in a separate transfer engine.

Progress through the sequence is driven only by interrupt flags. A bus-event flag closes each reset. A frame flag seen together with the send-buffer-available flag shows that the bus is running again. Each service cycle moves the machine by at most one step. The candidate steps are tested in a fixed priority order, and a detach is the lowest priority. While a descriptor fetch is in flight, interrupt servicing is suspended until the engine reports completion.

Top module: `usb_enum_seq`

## Requirements
- R1: While reset is asserted and after it is released, with no interrupt serviced, the state output is 0 and ack_we_o, sof_set_o, sof_clr_o and fetch_start_o are all low. The state codes are: 0 idle, 1 attached, 2 first reset, 3 probed, 4 second reset, 5 live.
- R2: While irq_n is high, no flags are acknowledged and the state does not change, whatever the flag byte holds.
- R3: A service cycle is an edge at which irq_n is low and no fetch is outstanding. One cycle after a service cycle, ack_we_o is high for one cycle and ack_data_o equals the flag byte sampled in that service cycle.
- R4: In state 0, a service with the connect flag (bit 5, 0x20) moves to state 1 only when attach_ok_i is high; with attach_ok_i low the state stays 0.
- R5: In state 1, a service with the bus-event flag (bit 0, 0x01) moves to state 2 and pulses sof_set_o for one cycle, visible in the same cycle as the new state.
- R6: In state 2, a service with the frame flag (bit 6, 0x40) and the send-available flag (bit 3, 0x08) both set pulses fetch_start_o for one cycle and leaves the state at 2. A frame flag without send-available has no effect.
- R7: While a fetch is outstanding, a low irq_n is not serviced: there is no acknowledge and no state change. A high fetch_done_i then moves the machine to state 3 one cycle later.
- R8: fetch_done_i has no effect when no fetch is outstanding.
- R9: In state 3, a service with the bus-event flag moves to state 4.
- R10: In state 4, a service with the frame and send-available flags moves to state 5 and pulses sof_clr_o for one cycle.
- R11: In any state other than 0, a service with the connect flag returns the machine to state 0, unless a higher-priority step of the current state matches. At most one step is taken per service; for example, 0x21 in state 1 gives state 2, and 0x68 in state 4 gives state 5.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| irq_n | input | 1 | Active-low interrupt line from the host controller |
| flags_i | input | FLAG_W | Host interrupt flag byte |
| attach_ok_i | input | 1 | Speed detector confirms a device is attached |
| fetch_done_i | input | 1 | Descriptor fetch engine has finished |
| ack_we_o | output | 1 | Acknowledge write strobe |
| ack_data_o | output | FLAG_W | Flags written back as acknowledge |
| sof_set_o | output | 1 | Request to set the SOF keep-alive mode bit |
| sof_clr_o | output | 1 | Request to clear the SOF keep-alive mode bit |
| fetch_start_o | output | 1 | Start pulse for the descriptor fetch |
| state_o | output | 3 | Current sequence state |

## Verification
The hardest situation to reach is an interrupt arriving while the descriptor fetch is still outstanding. The machine can only get there after a confirmed attach, a bus event, and a frame-with-send-available service. The bench therefore walks the full sequence up to the fetch pulse. It then holds irq_n low with a bus-event flag for several cycles before it raises fetch_done_i, and checks that nothing was acknowledged. Priority cases are reached by presenting combined flag bytes, such as connect together with bus event, in the states where two steps compete.

// File: rtl/usb_enum_pkg.sv
package usb_enum_pkg;

  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_ATTACHED = 3'd1,
    ST_RST1     = 3'd2,
    ST_PROBED   = 3'd3,
    ST_RST2     = 3'd4,
    ST_LIVE     = 3'd5
  } enum_state_e;

  // Bit positions inside the host interrupt flag byte
  localparam int BIT_BUS   = 0;
  localparam int BIT_SNDAV = 3;
  localparam int BIT_CONN  = 5;
  localparam int BIT_FRAME = 6;

  typedef struct packed {
    logic bus;
    logic conn;
    logic frame_ok;
  } evt_t;

endpackage

// File: rtl/usb_enum_decode.sv
module usb_enum_decode
  import usb_enum_pkg::*;
(
  input  logic irq_n,
  input  logic busy,
  input  logic bus_f,
  input  logic conn_f,
  input  logic frame_f,
  input  logic sndav_f,
  output logic service,
  output evt_t ev
);

  // Service only when the line is asserted and no fetch is outstanding
  always_comb begin
    service     = ~irq_n & ~busy;
    ev.bus      = bus_f;
    ev.conn     = conn_f;
    ev.frame_ok = frame_f & sndav_f;
  end

endmodule

// File: rtl/usb_enum_fsm.sv
module usb_enum_fsm
  import usb_enum_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        service,
  input  evt_t        ev,
  input  logic        attach_ok,
  input  logic        fetch_done,
  output enum_state_e state,
  output logic        pending,
  output logic        go_set,
  output logic        go_clr,
  output logic        go_fetch
);

  enum_state_e nxt_state;
  logic        nxt_pending;
  logic        upd_en;

  always_comb begin
    nxt_state   = state;
    nxt_pending = pending;
    go_set      = 1'b0;
    go_clr      = 1'b0;
    go_fetch    = 1'b0;
    if (pending) begin
      if (fetch_done) begin
        nxt_state   = ST_PROBED;
        nxt_pending = 1'b0;
      end
    end else if (service) begin
      // Fixed priority, one step per service
      if (state == ST_IDLE && ev.conn && attach_ok) begin
        nxt_state = ST_ATTACHED;
      end else if (state == ST_ATTACHED && ev.bus) begin
        nxt_state = ST_RST1;
        go_set    = 1'b1;
      end else if (state == ST_RST1 && ev.frame_ok) begin
        nxt_pending = 1'b1;
        go_fetch    = 1'b1;
      end else if (state == ST_PROBED && ev.bus) begin
        nxt_state = ST_RST2;
      end else if (state == ST_RST2 && ev.frame_ok) begin
        nxt_state = ST_LIVE;
        go_clr    = 1'b1;
      end else if (state != ST_IDLE && ev.conn) begin
        nxt_state = ST_IDLE;
      end
    end
  end

  assign upd_en = pending | service;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      pending <= 1'b0;
    end else if (upd_en) begin
      state   <= nxt_state;
      pending <= nxt_pending;
    end
  end

endmodule

// File: rtl/usb_enum_outreg.sv
module usb_enum_outreg #(
  parameter int FLAG_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              service,
  input  logic [FLAG_W-1:0] flags,
  input  logic              go_set,
  input  logic              go_clr,
  input  logic              go_fetch,
  output logic              ack_we,
  output logic [FLAG_W-1:0] ack_data,
  output logic              sof_set,
  output logic              sof_clr,
  output logic              fetch_start
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_we      <= 1'b0;
      sof_set     <= 1'b0;
      sof_clr     <= 1'b0;
      fetch_start <= 1'b0;
    end else begin
      ack_we      <= service;
      sof_set     <= go_set;
      sof_clr     <= go_clr;
      fetch_start <= go_fetch;
    end
  end

  // Acknowledge data captured only on a service cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_data <= '0;
    end else if (service) begin
      ack_data <= flags;
    end
  end

endmodule

// File: rtl/usb_enum_seq.sv
module usb_enum_seq
  import usb_enum_pkg::*;
#(
  parameter int FLAG_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              irq_n,
  input  logic [FLAG_W-1:0] flags_i,
  input  logic              attach_ok_i,
  input  logic              fetch_done_i,
  output logic              ack_we_o,
  output logic [FLAG_W-1:0] ack_data_o,
  output logic              sof_set_o,
  output logic              sof_clr_o,
  output logic              fetch_start_o,
  output logic [2:0]        state_o
);

  logic        service;
  logic        pending;
  logic        go_set;
  logic        go_clr;
  logic        go_fetch;
  evt_t        ev;
  enum_state_e state;

  usb_enum_decode u_decode (
    .irq_n   (irq_n),
    .busy    (pending),
    .bus_f   (flags_i[BIT_BUS]),
    .conn_f  (flags_i[BIT_CONN]),
    .frame_f (flags_i[BIT_FRAME]),
    .sndav_f (flags_i[BIT_SNDAV]),
    .service (service),
    .ev      (ev)
  );

  usb_enum_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .service    (service),
    .ev         (ev),
    .attach_ok  (attach_ok_i),
    .fetch_done (fetch_done_i),
    .state      (state),
    .pending    (pending),
    .go_set     (go_set),
    .go_clr     (go_clr),
    .go_fetch   (go_fetch)
  );

  usb_enum_outreg #(.FLAG_W(FLAG_W)) u_outreg (
    .clk         (clk),
    .rst_n       (rst_n),
    .service     (service),
    .flags       (flags_i),
    .go_set      (go_set),
    .go_clr      (go_clr),
    .go_fetch    (go_fetch),
    .ack_we      (ack_we_o),
    .ack_data    (ack_data_o),
    .sof_set     (sof_set_o),
    .sof_clr     (sof_clr_o),
    .fetch_start (fetch_start_o)
  );

  assign state_o = state;

endmodule

// File: rtl/usb_enum_seq_chk.sv
module usb_enum_seq_chk #(
  parameter int FLAG_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              irq_n,
  input logic [FLAG_W-1:0] flags_i,
  input logic              ack_we_o,
  input logic [FLAG_W-1:0] ack_data_o,
  input logic              sof_set_o,
  input logic              sof_clr_o,
  input logic              fetch_start_o,
  input logic [2:0]        state_o
);

  AST_QUIET_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_n |=> !ack_we_o); // R2

  AST_ACK_ECHO: assert property (@(posedge clk) disable iff (!rst_n)
    ack_we_o |-> (ack_data_o == $past(flags_i)) && !$past(irq_n)); // R3

  AST_SOF_SET_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    sof_set_o |-> (state_o == 3'd2) && ($past(state_o) == 3'd1)); // R5

  AST_FETCH_IN_RST1: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_start_o |-> (state_o == 3'd2)); // R6

  AST_FETCH_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_start_o |=> !ack_we_o); // R7

  AST_SOF_CLR_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    sof_clr_o |-> (state_o == 3'd5) && ($past(state_o) == 3'd4)); // R10

  AST_SINGLE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_o != $past(state_o)) && (state_o != 3'd0))
      |-> (state_o == $past(state_o) + 3'd1)); // R11

  AST_REQ_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sof_set_o, sof_clr_o, fetch_start_o})); // R11

endmodule

bind usb_enum_seq usb_enum_seq_chk #(.FLAG_W(FLAG_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .irq_n         (irq_n),
  .flags_i       (flags_i),
  .ack_we_o      (ack_we_o),
  .ack_data_o    (ack_data_o),
  .sof_set_o     (sof_set_o),
  .sof_clr_o     (sof_clr_o),
  .fetch_start_o (fetch_start_o),
  .state_o       (state_o)
);

// File: tb/usb_enum_seq_bench.sv
`timescale 1ns/1ps
module usb_enum_seq_bench;

  logic       clk;
  logic       rst_n;
  logic       irq_n;
  logic [7:0] flags_i;
  logic       attach_ok_i;
  logic       fetch_done_i;
  logic       ack_we_o;
  logic [7:0] ack_data_o;
  logic       sof_set_o;
  logic       sof_clr_o;
  logic       fetch_start_o;
  logic [2:0] state_o;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 0;

  usb_enum_seq u_usb_enum_seq (
    .clk           (clk),
    .rst_n         (rst_n),
    .irq_n         (irq_n),
    .flags_i       (flags_i),
    .attach_ok_i   (attach_ok_i),
    .fetch_done_i  (fetch_done_i),
    .ack_we_o      (ack_we_o),
    .ack_data_o    (ack_data_o),
    .sof_set_o     (sof_set_o),
    .sof_clr_o     (sof_clr_o),
    .fetch_start_o (fetch_start_o),
    .state_o       (state_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string req);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // One service cycle; sampling happens at the following falling edge
  task automatic serve(input logic [7:0] f, input logic att);
    @(negedge clk);
    irq_n = 1'b0; flags_i = f; attach_ok_i = att;
    @(negedge clk);
    irq_n = 1'b1; flags_i = 8'h00; attach_ok_i = 1'b0;
  endtask

  task automatic t_reset;
    rst_n = 1'b0; irq_n = 1'b1; flags_i = 8'h00; attach_ok_i = 1'b0; fetch_done_i = 1'b0;
    repeat (3) @(negedge clk);
    chk(state_o, 8'd0, "R1 state in reset");
    chk({ack_we_o, sof_set_o, sof_clr_o, fetch_start_o}, 8'd0, "R1 outputs in reset");
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(state_o, 8'd0, "R1 state after release");
    chk({ack_we_o, sof_set_o, sof_clr_o, fetch_start_o}, 8'd0, "R1 outputs after release");
  endtask

  task automatic t_quiet;
    @(negedge clk);
    irq_n = 1'b1; flags_i = 8'h21; attach_ok_i = 1'b1;
    repeat (3) begin
      @(negedge clk);
      chk(ack_we_o, 8'd0, "R2 no ack while line high");
      chk(state_o, 8'd0, "R2 no step while line high");
    end
    flags_i = 8'h00; attach_ok_i = 1'b0;
  endtask

  task automatic t_attach;
    serve(8'h20, 1'b0);
    chk(ack_we_o, 8'd1, "R3 ack strobe");
    chk(ack_data_o, 8'h20, "R3 ack data");
    chk(state_o, 8'd0, "R4 unconfirmed attach ignored");
    serve(8'h24, 1'b1);
    chk(ack_data_o, 8'h24, "R3 ack data echo");
    chk(state_o, 8'd1, "R4 attach confirmed");
    @(negedge clk);
    chk(ack_we_o, 8'd0, "R3 ack lasts one cycle");
  endtask

  task automatic t_first_reset;
    serve(8'h40, 1'b0);
    chk(state_o, 8'd1, "R5 frame alone in attached");
    serve(8'h01, 1'b0);
    chk(state_o, 8'd2, "R5 bus event to first reset");
    chk(sof_set_o, 8'd1, "R5 keep-alive set");
    @(negedge clk);
    chk(sof_set_o, 8'd0, "R5 set request one cycle");
  endtask

  task automatic t_fetch;
    serve(8'h40, 1'b0);
    chk(fetch_start_o, 8'd0, "R6 frame without send-available");
    chk(state_o, 8'd2, "R6 stays in first reset");
    serve(8'h48, 1'b0);
    chk(fetch_start_o, 8'd1, "R6 fetch pulse");
    chk(state_o, 8'd2, "R6 state holds during fetch");
    irq_n = 1'b0; flags_i = 8'h01;
    repeat (3) begin
      @(negedge clk);
      chk(ack_we_o, 8'd0, "R7 no service while fetching");
      chk(state_o, 8'd2, "R7 no step while fetching");
    end
    chk(fetch_start_o, 8'd0, "R6 fetch pulse one cycle");
    irq_n = 1'b1; flags_i = 8'h00; fetch_done_i = 1'b1;
    @(negedge clk);
    fetch_done_i = 1'b0;
    chk(state_o, 8'd3, "R7 done enters probed");
  endtask

  task automatic t_stray_done;
    fetch_done_i = 1'b1;
    repeat (2) @(negedge clk);
    fetch_done_i = 1'b0;
    @(negedge clk);
    chk(state_o, 8'd3, "R8 stray done ignored");
    chk(ack_we_o, 8'd0, "R8 stray done no ack");
  endtask

  task automatic t_second;
    serve(8'h48, 1'b0);
    chk(state_o, 8'd3, "R9 frame ignored in probed");
    serve(8'h01, 1'b0);
    chk(state_o, 8'd4, "R9 bus event to second reset");
    serve(8'h68, 1'b0);
    chk(state_o, 8'd5, "R11 ready beats detach");
    chk(sof_clr_o, 8'd1, "R10 keep-alive cleared");
    @(negedge clk);
    chk(sof_clr_o, 8'd0, "R10 clear request one cycle");
  endtask

  task automatic t_detach;
    serve(8'h20, 1'b0);
    chk(state_o, 8'd0, "R11 detach from live");
    serve(8'h20, 1'b1);
    chk(state_o, 8'd1, "R4 reattach");
    serve(8'h21, 1'b1);
    chk(state_o, 8'd2, "R11 bus beats detach");
    chk(sof_set_o, 8'd1, "R11 single step sets keep-alive");
    serve(8'h20, 1'b0);
    chk(state_o, 8'd0, "R11 detach from first reset");
  endtask

  initial begin
    t_reset();
    t_quiet();
    t_attach();
    t_first_reset();
    t_fetch();
    t_stray_done();
    t_second();
    t_detach();
    repeat (2) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_vec++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

endmodule